// File: doc/BRIEF.md
# Microword-Controlled ALU and Shifter

This block is the 32-bit arithmetic unit and output shifter of a microcoded datapath. It has no opcode decoder: an 8-bit control field taken directly from the microword drives it. Separate bits gate each operand, invert the left operand, supply the adder carry-in, pick one of four functions and apply an optional shift. Constants such as 0, -1, B+1 and B-1 therefore come from combinations of these bits rather than from dedicated operations.

Both operands arrive on ports from the register-selection logic outside the block. The block returns the shifted result together with a negative flag and a zero flag, which it takes from the unshifted function output. The block is purely combinational. Operand selection, register writeback and microsequencing stay outside it.

Top module: `mw_alu_shift`

## Requirements
- R1: The control field `ctl` has this layout, bit 7 first: bit 7 left-shift-by-8, bit 6 arithmetic-right-by-1, bits 5:4 function select {F0,F1}, bit 3 left-operand enable, bit 2 right-operand enable, bit 1 left-operand invert, bit 0 carry-in.
- R2: When an operand enable bit is 0, that operand is replaced by zero. When it is 1, the operand passes unchanged.
- R3: The invert bit complements the left operand after gating, so a disabled and inverted left operand equals all ones (-1).
- R4: Function select {F0,F1}: 00 gives A AND B, 01 gives A OR B, 10 gives NOT B, and 11 gives A + B + carry-in, modulo 2^32.
- R5: The carry-in bit changes only the sum function. For the three logic functions it has no effect on any output.
- R6: When bit 7 is set, the result is the function output shifted left by 8, with zeros filling the low byte.
- R7: When bit 6 is set, the result is the function output shifted right by 1, with bit 31 copied into bit 31.
- R8: When bits 7 and 6 are both 0, the result equals the function output.
- R9: `flag_neg` equals bit 31 of the function output before shifting.
- R10: `flag_zero` is 1 exactly when the 32-bit function output before shifting is zero, whatever the shift does.
- R11: The two shift bits are never set together. Each one, applied by itself, acts alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl | input | 8 | Microword ALU/shift control field (layout in R1) |
| opnd_a | input | 32 | Left operand |
| opnd_b | input | 32 | Right operand |
| result | output | 32 | Shifted function output |
| flag_neg | output | 1 | Sign of the unshifted function output |
| flag_zero | output | 1 | Unshifted function output is zero |

## Verification
On every evaluation, the assertions check the shift bits for exclusivity, the zero fill of the low byte under the left shift, and the sign copy under the right shift. They also check the agreement between the flags and the result when no shift is applied, and the all-ones constant built from a disabled, inverted left operand. The scenarios alone show the correctness of each function's value, the effect of the carry-in in the sum and its absence elsewhere, and the wrap-around of increment. They also show the flags taken before the shift, such as a zero flag of 0 when a right shift empties the result.

// File: rtl/mw_alu_pkg.sv
package mw_alu_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_SUM  = 2'b11
  } alu_fn_e;

  // Bit 7 first; fn holds {F0,F1}
  typedef struct packed {
    logic    sll8;
    logic    sra1;
    alu_fn_e fn;
    logic    ena;
    logic    enb;
    logic    inva;
    logic    inc;
  } mw_ctl_t;

  localparam int unsigned CTL_W = $bits(mw_ctl_t);

endpackage

// File: rtl/alu_opnd_gate.sv
module alu_opnd_gate #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ena,
  input  logic         enb,
  input  logic         inva,
  output logic [W-1:0] a_gated,
  output logic [W-1:0] b_gated
);

  // per-bit gating cells: enable AND, then optional XOR invert on A
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign a_gated[i] = (a_in[i] & ena) ^ inva;
    assign b_gated[i] = b_in[i] & enb;
  end

endmodule

// File: rtl/alu_func_core.sv
module alu_func_core
  import mw_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_g,
  input  logic [W-1:0] b_g,
  input  alu_fn_e      fn,
  input  logic         cin,
  output logic [W-1:0] f_out
);

  logic [W-1:0] sum_v;

  assign sum_v = a_g + b_g + {{(W-1){1'b0}}, cin};

  always_comb begin
    unique case (fn)
      FN_AND:  f_out = a_g & b_g;
      FN_OR:   f_out = a_g | b_g;
      FN_NOTB: f_out = ~b_g;
      default: f_out = sum_v;
    endcase
  end

  // R4: OR with a zero left operand passes the right operand
  always_comb begin
    if (fn == FN_OR && a_g == '0)
      assert_or_pass_R4: assert (f_out == b_g)
        else $error("OR with zero A did not pass B");
  end

endmodule

// File: rtl/alu_out_shift.sv
module alu_out_shift #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHL = 8
) (
  input  logic [W-1:0] d_in,
  input  logic         shl_en,
  input  logic         sra_en,
  output logic [W-1:0] d_out
);

  logic [W-1:0] shl_v;
  logic [W-1:0] sra_v;

  generate
    if (SHL < W) begin : g_shl
      assign shl_v = {d_in[W-1-SHL:0], {SHL{1'b0}}};
    end else begin : g_shl_all
      assign shl_v = '0;
    end
  endgenerate

  assign sra_v = {d_in[W-1], d_in[W-1:1]};

  always_comb begin
    if (shl_en)      d_out = shl_v;
    else if (sra_en) d_out = sra_v;
    else             d_out = d_in;
  end

endmodule

// File: rtl/mw_alu_shift.sv
module mw_alu_shift
  import mw_alu_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned SHL = 8
) (
  input  logic [7:0]   ctl,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         flag_neg,
  output logic         flag_zero
);

  mw_ctl_t      c;
  logic [W-1:0] a_g;
  logic [W-1:0] b_g;
  logic [W-1:0] f_raw;

  assign c = mw_ctl_t'(ctl[CTL_W-1:0]);

  alu_opnd_gate #(.W(W)) u_gate (
    .a_in   (opnd_a),
    .b_in   (opnd_b),
    .ena    (c.ena),
    .enb    (c.enb),
    .inva   (c.inva),
    .a_gated(a_g),
    .b_gated(b_g)
  );

  alu_func_core #(.W(W)) u_core (
    .a_g  (a_g),
    .b_g  (b_g),
    .fn   (c.fn),
    .cin  (c.inc),
    .f_out(f_raw)
  );

  alu_out_shift #(.W(W), .SHL(SHL)) u_shift (
    .d_in  (f_raw),
    .shl_en(c.sll8),
    .sra_en(c.sra1),
    .d_out (result)
  );

  assign flag_neg  = f_raw[W-1];
  assign flag_zero = (f_raw == '0);

  always_comb begin
    assert_shift_excl_R11: assert (!(ctl[7] && ctl[6]))
      else $error("both shift bits set");
    if (ctl[7])
      assert_sll_fill_R6: assert (result[SHL-1:0] == '0)
        else $error("left shift low byte not zero");
    if (ctl[6] && !ctl[7])
      assert_sra_sign_R7: assert (result[W-1] == flag_neg)
        else $error("right shift lost sign");
    if (!ctl[7] && !ctl[6])
      assert_flags_unshifted_R9: assert (result[W-1] == flag_neg && (flag_zero == (result == '0)))
        else $error("flags disagree with unshifted result");
    if (ctl[5:0] == 6'b110010)
      assert_neg_one_R3: assert (flag_neg && !flag_zero && &f_raw)
        else $error("disabled inverted A is not -1");
  end

endmodule

// File: tb/test_mw_alu_shift.sv
module test_mw_alu_shift;

  typedef struct {
    logic [31:0] res;
    logic        n;
    logic        z;
    string       tag;
  } exp_t;

  logic        clk;
  logic [7:0]  ctl;
  logic [31:0] opnd_a, opnd_b, result;
  logic        flag_neg, flag_zero;
  int          n_checks = 0;
  int          n_fails  = 0;
  bit          done     = 0;
  exp_t        sb_q[$];

  mw_alu_shift i_mw_alu_shift (
    .ctl(ctl), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .flag_neg(flag_neg), .flag_zero(flag_zero)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic exp_t model(logic [7:0] k, logic [31:0] a, logic [31:0] b, string tag);
    exp_t        e;
    logic [31:0] ag, bg, raw;
    ag = k[3] ? a : 32'h0;
    if (k[1]) ag = ~ag;
    bg = k[2] ? b : 32'h0;
    case (k[5:4])
      2'b00:   raw = ag & bg;
      2'b01:   raw = ag | bg;
      2'b10:   raw = ~bg;
      default: raw = ag + bg + {31'h0, k[0]};
    endcase
    e.n = raw[31];
    e.z = (raw == 32'h0);
    if (k[7])      e.res = raw << 8;
    else if (k[6]) e.res = {raw[31], raw[31:1]};
    else           e.res = raw;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(logic [7:0] k, logic [31:0] a, logic [31:0] b, string tag);
    @(posedge clk);
    ctl = k; opnd_a = a; opnd_b = b;
    sb_q.push_back(model(k, a, b, tag));
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_checks++;
        if (result !== e.res || flag_neg !== e.n || flag_zero !== e.z) begin
          n_fails++;
          $display("FAIL %s: got res=%h n=%b z=%b, expected res=%h n=%b z=%b",
                   e.tag, result, flag_neg, flag_zero, e.res, e.n, e.z);
        end
      end
    end
  end

  initial begin
    ctl = 8'h00; opnd_a = 32'h0; opnd_b = 32'h0;
    drive(8'h00, 32'h0, 32'h0, "R2 idle all zero, z set");
    drive(8'h3C, 32'h0000_1234, 32'h0000_0F0F, "R1 R4 sum A+B");
    drive(8'h35, 32'hDEAD_BEEF, 32'h0000_00FF, "R2 R4 increment B+1");
    drive(8'h36, 32'h1111_1111, 32'h0000_0010, "R3 decrement B-1");
    drive(8'h32, 32'h5555_5555, 32'h7777_7777, "R3 constant -1");
    drive(8'h34, 32'hFFFF_FFFF, 32'h8000_0001, "R2 pass B, n set");
    drive(8'h38, 32'h0000_4242, 32'hFFFF_FFFF, "R2 B disabled passes A");
    drive(8'h3F, 32'h0000_0005, 32'h0000_0003, "R4 B-A negative");
    drive(8'h0C, 32'hF0F0_F0F0, 32'hFF00_FF00, "R4 AND");
    drive(8'h1C, 32'hF0F0_0000, 32'h000F_000F, "R4 OR");
    drive(8'h24, 32'h1234_5678, 32'h0F0F_0F0F, "R4 NOT B");
    drive(8'h15, 32'h0, 32'h0000_0100, "R5 OR ignores carry-in");
    drive(8'h0D, 32'hF0F0_F0F0, 32'hFF00_FF00, "R5 AND ignores carry-in");
    drive(8'h25, 32'h0, 32'h0000_FFFF, "R5 NOT B ignores carry-in");
    drive(8'h35, 32'h0, 32'hFFFF_FFFF, "R4 R10 increment wraps to zero");
    drive(8'hB4, 32'h0, 32'h0080_1234, "R6 R9 left shift, n from pre-shift");
    drive(8'h74, 32'h0, 32'h8000_0000, "R7 arithmetic right keeps sign");
    drive(8'h74, 32'h0, 32'h0000_0001, "R7 R10 right shift empties, z clear");
    drive(8'hB4, 32'h0, 32'hFF00_0000, "R6 R10 left shift empties, z clear");
    drive(8'h1C, 32'h8000_0000, 32'h0000_0000, "R8 R9 unshifted sign");
    drive(8'hB4, 32'h0, 32'h0000_00AB, "R11 left shift alone");
    drive(8'h74, 32'h0, 32'h0000_00AB, "R11 right shift alone");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule